// File: doc/BRIEF.md
# Infrared Carrier Waveform Generator

This block produces the square-wave carrier used by an infrared remote-control transmitter. It runs on the oscillator clock itself, not on a divided system clock. Software sets the length of the mark (high) part and the length of the space (low) part of each carrier period as two separate 8-bit counts. Each count is loaded through two 4-bit write ports, one for the lower nibble and one for the upper nibble. A mark count of M gives a high phase of M+1 clocks. A space count of S gives a low phase of S+1 clocks. The carrier period is therefore M+S+2 clocks. For example, M+S+2 = 105 at a 4 MHz clock gives a carrier of about 38.1 kHz.

A single port data bit (`pin_bit`) gates the carrier onto the high-current output pin. While `pin_bit` is 1, the pin carries the modulated waveform. While it is 0, the pin is held low and the phase counter is held at its start. Every burst therefore begins with a complete high phase. The output is a combinational AND of `pin_bit` and the current phase, so the pin responds in the same cycle that `pin_bit` changes.

Top module: `ir_carrier_gen`

## Requirements
- R1: While `pin_bit` is 1, each high phase of `carrier_out` lasts M+1 clock cycles, where M = {mark_hi_d nibble, mark_lo_d nibble} (upper nibble in bits 7:4, lower nibble in bits 3:0).
- R2: While `pin_bit` is 1, each low phase lasts S+1 clock cycles, where S = {space_hi_d, space_lo_d} (upper nibble in bits 7:4).
- R3: The carrier period is M+S+2 clocks, and the high and low phases strictly alternate.
- R4: While `pin_bit` is 0, `carrier_out` is 0 in every cycle and the phase counter is held at its start.
- R5: In the cycle in which `pin_bit` goes from 0 to 1, `carrier_out` becomes 1 and begins a full high phase of M+1 clocks.
- R6: A new mark or space value written while the carrier runs takes effect only at the next start of the matching phase. The phase already in progress keeps its old length.
- R7: Synchronous active-high reset clears all four nibble registers to 0. With `pin_bit` at 0, `carrier_out` is 0. After reset, enabling the carrier gives alternating 1 and 0 single-clock phases.
- R8: A write on one nibble port changes only that nibble. The other nibble of the same count keeps its value.
- R9: The phase counter never exceeds the length latched for the current phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| mark_lo_we | input | 1 | Write enable, mark count bits 3:0 |
| mark_lo_d | input | 4 | Write data, mark count bits 3:0 |
| mark_hi_we | input | 1 | Write enable, mark count bits 7:4 |
| mark_hi_d | input | 4 | Write data, mark count bits 7:4 |
| space_lo_we | input | 1 | Write enable, space count bits 3:0 |
| space_lo_d | input | 4 | Write data, space count bits 3:0 |
| space_hi_we | input | 1 | Write enable, space count bits 7:4 |
| space_hi_d | input | 4 | Write data, space count bits 7:4 |
| pin_bit | input | 1 | Output-pin data bit; 1 passes the carrier, 0 holds the pin low |
| carrier_out | output | 1 | Modulated carrier to the output driver |

## Verification
The assertions check on every cycle that:
- the counter stays within its latched length;
- the latched length does not change in the middle of a phase;
- every terminal count flips the phase;
- a rising `pin_bit` finds the counter at the start of a high phase;
- each nibble write lands in its own register.

Only the bench scenarios can show the actual run lengths on the pin. These scenarios cover random mark and space counts, both 0 and 255 extremes, writes made in the middle of a phase, partial nibble updates, and a burst cut short and restarted.

// File: rtl/ircar_pkg.sv
package ircar_pkg;
    localparam int NIB_W  = 4;
    localparam int NIB_N  = 2;
    localparam int NREG   = 2;
    localparam int NPORT  = NIB_N * NREG;

    typedef enum logic {
        PH_SPACE = 1'b0,
        PH_MARK  = 1'b1
    } phase_e;

    function automatic phase_e other_phase(phase_e p);
        return (p == PH_MARK) ? PH_SPACE : PH_MARK;
    endfunction
endpackage

// File: rtl/ircar_regs.sv
module ircar_regs #(
    parameter int NIB_W = ircar_pkg::NIB_W,
    parameter int NPORT = ircar_pkg::NPORT,
    localparam int LEN_W = NIB_W * 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NPORT-1:0]            we,
    input  logic [NPORT-1:0][NIB_W-1:0] wd,
    output logic [LEN_W-1:0]            mark_len,
    output logic [LEN_W-1:0]            space_len
);
    logic [NPORT-1:0][NIB_W-1:0] nib;

    for (genvar i = 0; i < NPORT; i++) begin : g_nib
        always_ff @(posedge clk) begin
            if (rst)        nib[i] <= '0;
            else if (we[i]) nib[i] <= wd[i];
        end

        assert_nibble_load_R8: assert property (@(posedge clk) disable iff (rst)
            we[i] |=> nib[i] == $past(wd[i]));
    end

    // Port order: 0 mark lower, 1 mark upper, 2 space lower, 3 space upper
    assign mark_len  = {nib[1], nib[0]};
    assign space_len = {nib[3], nib[2]};
endmodule

// File: rtl/ircar_phase.sv
module ircar_phase
    import ircar_pkg::*;
#(
    parameter int LEN_W = 2 * ircar_pkg::NIB_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [LEN_W-1:0] mark_len,
    input  logic [LEN_W-1:0] space_len,
    output phase_e           phase
);
    logic [LEN_W-1:0] cnt;
    logic [LEN_W-1:0] cur_len;
    logic             at_end;

    assign at_end = (cnt == cur_len);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            phase   <= PH_MARK;
            cnt     <= '0;
            cur_len <= mark_len;
        end else if (at_end) begin
            cnt     <= '0;
            phase   <= other_phase(phase);
            cur_len <= (phase == PH_MARK) ? space_len : mark_len;
        end else begin
            cnt     <= cnt + 1'b1;
        end
    end

    assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (rst)
        cnt <= cur_len);

    assert_len_stable_R6: assert property (@(posedge clk) disable iff (rst)
        (run && !at_end) |=> $stable(cur_len));

    assert_phase_flip_R3: assert property (@(posedge clk) disable iff (rst)
        (run && at_end) |=> phase != $past(phase));

    assert_burst_start_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(run) |-> (phase == PH_MARK && cnt == '0));
endmodule

// File: rtl/ircar_gate.sv
module ircar_gate
    import ircar_pkg::*;
(
    input  logic   run,
    input  phase_e phase,
    output logic   pin_out
);
    assign pin_out = run && (phase == PH_MARK);
endmodule

// File: rtl/ir_carrier_gen.sv
module ir_carrier_gen
    import ircar_pkg::*;
#(
    parameter int NW = ircar_pkg::NIB_W,
    localparam int LW = 2 * NW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mark_lo_we,
    input  logic [NW-1:0] mark_lo_d,
    input  logic          mark_hi_we,
    input  logic [NW-1:0] mark_hi_d,
    input  logic          space_lo_we,
    input  logic [NW-1:0] space_lo_d,
    input  logic          space_hi_we,
    input  logic [NW-1:0] space_hi_d,
    input  logic          pin_bit,
    output logic          carrier_out
);
    logic [NPORT-1:0]         we;
    logic [NPORT-1:0][NW-1:0] wd;
    logic [LW-1:0]            mark_len;
    logic [LW-1:0]            space_len;
    phase_e                   phase;

    assign we = {space_hi_we, space_lo_we, mark_hi_we, mark_lo_we};
    assign wd = {space_hi_d, space_lo_d, mark_hi_d, mark_lo_d};

    ircar_regs #(.NIB_W(NW), .NPORT(NPORT)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .we        (we),
        .wd        (wd),
        .mark_len  (mark_len),
        .space_len (space_len)
    );

    ircar_phase #(.LEN_W(LW)) u_phase (
        .clk       (clk),
        .rst       (rst),
        .run       (pin_bit),
        .mark_len  (mark_len),
        .space_len (space_len),
        .phase     (phase)
    );

    ircar_gate u_gate (
        .run     (pin_bit),
        .phase   (phase),
        .pin_out (carrier_out)
    );
endmodule

// File: tb/sim_ir_carrier_gen.sv
module sim_ir_carrier_gen;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 200000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mark_lo_we = 0, mark_hi_we = 0, space_lo_we = 0, space_hi_we = 0;
    logic [3:0] mark_lo_d = 0, mark_hi_d = 0, space_lo_d = 0, space_hi_d = 0;
    logic       pin_bit = 0;
    logic       carrier_out;

    int n_checks = 0;
    int n_errors = 0;
    int runs [8];
    logic first_level;

    always #(CLK_PERIOD/2) clk = ~clk;

    ir_carrier_gen u0 (
        .clk(clk), .rst(rst),
        .mark_lo_we(mark_lo_we), .mark_lo_d(mark_lo_d),
        .mark_hi_we(mark_hi_we), .mark_hi_d(mark_hi_d),
        .space_lo_we(space_lo_we), .space_lo_d(space_lo_d),
        .space_hi_we(space_hi_we), .space_hi_d(space_hi_d),
        .pin_bit(pin_bit), .carrier_out(carrier_out)
    );

    function automatic int hi_len(int m);
        return m + 1;
    endfunction

    function automatic int lo_len(int s);
        return s + 1;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Inputs are driven on negedge; both counts written together
    task automatic set_counts(input int m, input int s);
        @(negedge clk);
        mark_lo_we = 1; mark_lo_d = m[3:0]; mark_hi_we = 1; mark_hi_d = m[7:4];
        space_lo_we = 1; space_lo_d = s[3:0]; space_hi_we = 1; space_hi_d = s[7:4];
        @(negedge clk);
        mark_lo_we = 0; mark_hi_we = 0; space_lo_we = 0; space_hi_we = 0;
        @(negedge clk);
    endtask

    // Sampling happens 1 time unit after each negedge
    task automatic measure(input int nruns);
        int   idx = 0;
        int   cur = 0;
        logic v;
        #1;
        v = carrier_out;
        first_level = v;
        while (idx < nruns) begin
            if (carrier_out == v) cur++;
            else begin
                runs[idx] = cur; idx++; v = carrier_out; cur = 1;
            end
            @(negedge clk); #1;
        end
    endtask

    task automatic start_burst(input int nruns);
        @(negedge clk);
        pin_bit = 1;
        measure(nruns);
    endtask

    task automatic stop_burst();
        @(negedge clk);
        pin_bit = 0;
        @(negedge clk);
    endtask

    task automatic check_pattern(input int m, input int s, input int nruns, input string tag);
        start_burst(nruns);
        check(first_level == 1'b1, {tag, " R5 burst starts high"}, first_level, 1);
        for (int k = 0; k < nruns; k++) begin
            if (k % 2 == 0) check(runs[k] == hi_len(m), {tag, " R1 high run"}, runs[k], hi_len(m));
            else            check(runs[k] == lo_len(s), {tag, " R2 low run"}, runs[k], lo_len(s));
        end
        stop_burst();
    endtask

    initial begin
        #(CLK_PERIOD * MAX_CYCLES);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd4242);

        // R7: reset state
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        check(carrier_out == 1'b0, "R7 output low after reset", carrier_out, 0);
        check_pattern(0, 0, 6, "R7 cleared counts");

        // R3: about 38 kHz case, period 105
        set_counts(51, 52);
        start_burst(2);
        check(runs[0] + runs[1] == 105, "R3 period", runs[0] + runs[1], 105);
        stop_burst();

        // R1/R2 extremes
        set_counts(255, 0);
        check_pattern(255, 0, 3, "max mark");
        set_counts(0, 255);
        check_pattern(0, 255, 3, "max space");

        // R8: single nibble writes
        set_counts(0, 1);
        @(negedge clk); mark_hi_we = 1; mark_hi_d = 4'h1;
        @(negedge clk); mark_hi_we = 0;
        @(negedge clk);
        check_pattern(16, 1, 2, "R8 upper nibble only");
        @(negedge clk); mark_lo_we = 1; mark_lo_d = 4'h3;
        @(negedge clk); mark_lo_we = 0;
        @(negedge clk);
        check_pattern(19, 1, 2, "R8 lower nibble only");

        // R6: new values written mid high phase
        set_counts(10, 5);
        @(negedge clk);
        pin_bit = 1;
        fork
            measure(4);
            begin
                repeat (3) @(negedge clk);
                mark_lo_we = 1; mark_lo_d = 4'h2; space_lo_we = 1; space_lo_d = 4'h7;
                @(negedge clk);
                mark_lo_we = 0; space_lo_we = 0;
            end
        join
        check(runs[0] == 11, "R6 current high keeps old length", runs[0], 11);
        check(runs[1] == 8,  "R6 low uses new length", runs[1], 8);
        check(runs[2] == 3,  "R6 next high uses new length", runs[2], 3);
        check(runs[3] == 8,  "R6 low repeats new length", runs[3], 8);
        stop_burst();

        // R4: burst cut in middle of high, then restarted
        set_counts(10, 5);
        @(negedge clk); pin_bit = 1;
        repeat (4) @(negedge clk);
        pin_bit = 0;
        for (int c = 0; c < 20; c++) begin
            #1;
            check(carrier_out == 1'b0, "R4 pin held low", carrier_out, 0);
            @(negedge clk);
        end
        check_pattern(10, 5, 2, "R4 restart full high");

        // Random counts
        for (int it = 0; it < 6; it++) begin
            int m = $urandom_range(0, 40);
            int s = $urandom_range(0, 40);
            set_counts(m, s);
            check_pattern(m, s, 4, "random");
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule